// File: doc/BRIEF.md
# ECC Memory Scrubbing Controller

This block owns a single-port, word-addressed storage array in which every word is kept as a SEC/DED codeword. Data written through the user port is encoded on the way in. Data read back is decoded: any single flipped bit is repaired and flagged, and any two flipped bits are reported as uncorrectable. Repairing only the returned value would leave the stored copy damaged, where a second upset could later make it unrecoverable. The controller therefore writes a repaired codeword back into the array in two situations.

The first is a user read. When a read finds a one-bit fault, the controller spends one extra cycle writing the corrected codeword back to that address before it accepts the next request. The second is a background sweep. Once every programmable number of clock cycles it starts a pass over all addresses. In cycles where the user port is idle, it reads one word, checks it and writes back a repaired copy when that is needed.

User traffic always has priority over the sweep. A pending sweep write-back is dropped when a user write to the same address overtakes it. Saturating counters track faults repaired on user reads, faults repaired by the sweep, and uncorrectable words. The most recent uncorrectable address is held for inspection.

Top module: `ecc_scrub_ctrl`

## Requirements
- R1: The stored codeword is DATA_W data bits plus enough Hamming bits for single-error location, plus one overall parity bit. That gives 72 bits for 64 data bits and 36 bits for 29 data bits. A read accepted on a clock edge drives rspValid, with the stored data and both fault flags low, during the following cycle only.
- R2: A read of a word that has any one stored bit flipped, including bit 0 and the top bit, returns the original data with rspSbe high. The user-read fault counter then rises by one.
- R3: After a response with rspSbe high, reqReady stays low for exactly one more cycle while the repaired codeword is written back. A later read of that address reports no fault.
- R4: A read of a word with two stored bits flipped raises rspDbe and never rspSbe. The word is not rewritten, so a repeat read flags it again. One cycle after the response, uePulse is high for one cycle, ueAddr holds the address, and the uncorrectable counter has risen by one.
- R5: A user write is accepted in one cycle with no response, and reqReady is high again in the next cycle. It stores a fresh codeword, so a fault at that address before the write is gone and no counter moves.
- R6: With a nonzero cfgInterval, a sweep pass starts each time that many cycles have elapsed while no pass is running. It visits addresses 0 to the last in order. It repairs one-bit faults in the array and counts them in cntSweepSbe. It counts two-bit faults as uncorrectable and captures their address.
- R7: A cfgInterval of zero stops the sweep: stored faults stay in place and cntSweepSbe does not change.
- R8: A user request that arrives while the controller is idle is accepted in that cycle, even with the sweep running. Back-to-back writes are therefore accepted on every cycle.
- R9: A user write to the address whose sweep write-back is still pending cancels that write-back, so the newly written data survives.
- R10: All counters are zero after reset and stop at their all-ones value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | User request present |
| reqReady | output | 1 | Controller accepts a request this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Word address |
| reqWdata | input | DATA_W | Write data |
| rspValid | output | 1 | Read response present |
| rspData | output | DATA_W | Corrected read data |
| rspSbe | output | 1 | Response had a one-bit fault, repaired |
| rspDbe | output | 1 | Response had an uncorrectable fault |
| cfgInterval | input | IV_W | Cycles between sweep passes, 0 disables |
| uePulse | output | 1 | One-cycle pulse on an uncorrectable word |
| ueAddr | output | ADDR_W | Address of the latest uncorrectable word |
| cntUserSbe | output | CNT_W | One-bit faults repaired on user reads |
| cntSweepSbe | output | CNT_W | One-bit faults found by the sweep |
| cntDbe | output | CNT_W | Uncorrectable words seen |

## Verification
A read accepted at a clock edge puts its response in the next cycle. The counters, uePulse and ueAddr settle one cycle later, and reqReady returns either in that same cycle or one cycle after it, when a write-back is needed. The bench drives on falling edges and samples each of these results at the falling edge of the exact cycle it is due in. Sweep results take a variable number of cycles to appear, so the bench polls the sweep counter with a cycle limit. When the counter moves, the bench waits a few cycles for the write-back to finish before it checks the array through ordinary reads. The cancellation case is driven at the falling edge just after the sweep counter moves, which is the one cycle in which the sweep write-back is pending.

// File: rtl/ecc_scrub_pkg.sv
package ecc_scrub_pkg;

  // number of check bits (Hamming bits plus one overall parity bit)
  function automatic int chkBits(int dataW);
    int r = 1;
    while ((1 << r) < dataW + r + 1) r++;
    return r + 1;
  endfunction

  typedef enum logic [1:0] {SRC_USER, SRC_UFIX, SRC_SFIX} wsrc_e;

  typedef enum logic [1:0] {ST_IDLE, ST_UCHK, ST_UFIX, ST_SCHK} state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic  memWe;
    logic  memRe;
    wsrc_e wrSrc;
    logic  keepUfix;
    logic  keepSfix;
    logic  bumpUser;
    logic  bumpSweep;
    logic  bumpDbe;
    logic  grabUe;
  } strobe_t;

endpackage

// File: rtl/ecc_secded_codec.sv
module ecc_secded_codec
  import ecc_scrub_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int CHK_W = chkBits(DATA_W),
  localparam int CW = DATA_W + CHK_W
) (
  input  logic [DATA_W-1:0] dataIn,
  output logic [CW-1:0]     codeOut,
  input  logic [CW-1:0]     codeIn,
  output logic [DATA_W-1:0] dataOut,
  output logic [CW-1:0]     fixedCode,
  output logic              sbe,
  output logic              dbe
);
  localparam int HB = CHK_W - 1;

  // position of the idx-th data bit: positions that are not powers of two
  function automatic int dataPosOf(int idx);
    int k = 0;
    for (int p = 1; p < CW; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (k == idx) return p;
        k++;
      end
    end
    return 0;
  endfunction

  // positions covered by Hamming bit j
  function automatic logic [CW-1:0] maskOf(int j);
    logic [CW-1:0] m = '0;
    for (int p = 1; p < CW; p++)
      if (((p >> j) & 1) == 1) m = m | (CW'(1) << p);
    return m;
  endfunction

  logic [CW-1:0] spread;
  logic [CW-1:1] body;
  logic [CW-1:0] flip;
  logic [HB-1:0] hpar;
  logic [HB-1:0] syn;
  logic          ovr;

  for (genvar i = 0; i < DATA_W; i++) begin : g_data
    localparam int P = dataPosOf(i);
    assign spread[P] = dataIn[i];
    assign dataOut[i] = fixedCode[P];
  end

  for (genvar j = 0; j < HB; j++) begin : g_ham
    localparam logic [CW-1:0] M = maskOf(j);
    assign hpar[j] = ^(spread & M);
    assign syn[j]  = ^(codeIn & M);
  end

  for (genvar p = 0; p < CW; p++) begin : g_pos
    if (p == 0 || (p & (p - 1)) == 0) begin : g_zero
      assign spread[p] = 1'b0;
    end
    if (p > 0) begin : g_body
      if ((p & (p - 1)) == 0) begin : g_par
        assign body[p] = hpar[$clog2(p)];
      end else begin : g_dat
        assign body[p] = spread[p];
      end
    end
    assign flip[p] = ovr && (syn == HB'(p));
  end

  assign codeOut   = {body, ^body};
  assign ovr       = ^codeIn;
  assign fixedCode = codeIn ^ flip;
  assign sbe       = |flip;
  assign dbe       = (ovr & ~(|flip)) | (~ovr & (|syn));
endmodule

// File: rtl/ecc_scrub_dp.sv
module ecc_scrub_dp
  import ecc_scrub_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              chkSbe,
  output logic              chkDbe,
  output logic              uePulse,
  output logic [ADDR_W-1:0] ueAddr,
  output logic [CNT_W-1:0]  cntUserSbe,
  output logic [CNT_W-1:0]  cntSweepSbe,
  output logic [CNT_W-1:0]  cntDbe
);
  localparam int CW    = DATA_W + chkBits(DATA_W);
  localparam int DEPTH = 1 << ADDR_W;

  logic [CW-1:0]     mem [DEPTH];
  logic [CW-1:0]     rdWord, encWord, fixedWord, ufixWord, sfixWord, wrWord;
  logic [ADDR_W-1:0] rdAddrQ;

  ecc_secded_codec #(.DATA_W(DATA_W)) uCodec (
    .dataIn(wrData), .codeOut(encWord), .codeIn(rdWord), .dataOut(rdData),
    .fixedCode(fixedWord), .sbe(chkSbe), .dbe(chkDbe)
  );

  always_comb begin
    unique case (stb.wrSrc)
      SRC_UFIX: wrWord = ufixWord;
      SRC_SFIX: wrWord = sfixWord;
      default:  wrWord = encWord;
    endcase
  end

  // array and holding registers, no reset
  always_ff @(posedge clk) begin
    if (stb.memWe) mem[memAddr] <= wrWord;
    if (stb.memRe) begin
      rdWord  <= mem[memAddr];
      rdAddrQ <= memAddr;
    end
    if (stb.keepUfix) ufixWord <= fixedWord;
    if (stb.keepSfix) sfixWord <= fixedWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntUserSbe  <= '0;
      cntSweepSbe <= '0;
      cntDbe      <= '0;
      uePulse     <= 1'b0;
      ueAddr      <= '0;
    end else begin
      if (stb.bumpUser && cntUserSbe != '1) cntUserSbe <= cntUserSbe + 1'b1;
      if (stb.bumpSweep && cntSweepSbe != '1) cntSweepSbe <= cntSweepSbe + 1'b1;
      if (stb.bumpDbe && cntDbe != '1) cntDbe <= cntDbe + 1'b1;
      uePulse <= stb.grabUe;
      if (stb.grabUe) ueAddr <= rdAddrQ;
    end
  end
endmodule

// File: rtl/ecc_scrub_ctl.sv
module ecc_scrub_ctl
  import ecc_scrub_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int IV_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [IV_W-1:0]   cfgInterval,
  input  logic              chkSbe,
  input  logic              chkDbe,
  output logic              reqReady,
  output logic              rspValid,
  output strobe_t           stb,
  output logic [ADDR_W-1:0] memAddr
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

  state_e            st, stNext;
  logic [ADDR_W-1:0] uAddrQ, swAddr;
  logic              swOn, swPend;
  logic [IV_W-1:0]   tmr;
  logic              accept, userWr, pendCancel, pendDone, sweepStep, expire;

  assign accept     = (st == ST_IDLE) && reqValid;
  assign userWr     = accept && reqWrite;
  assign pendCancel = userWr && swPend && (reqAddr == swAddr);
  assign pendDone   = (st == ST_IDLE) && !reqValid && swPend;
  assign sweepStep  = pendCancel || pendDone || (st == ST_SCHK && !chkSbe);
  assign expire     = (cfgInterval != '0) && (tmr >= cfgInterval - 1'b1);

  always_comb begin
    stb       = '0;
    stb.wrSrc = SRC_USER;
    memAddr   = reqAddr;
    stNext    = st;
    reqReady  = (st == ST_IDLE);
    rspValid  = (st == ST_UCHK);
    unique case (st)
      ST_IDLE: begin
        if (reqValid) begin
          if (reqWrite) stb.memWe = 1'b1;
          else begin
            stb.memRe = 1'b1;
            stNext    = ST_UCHK;
          end
        end else if (swPend) begin
          stb.memWe = 1'b1;
          stb.wrSrc = SRC_SFIX;
          memAddr   = swAddr;
        end else if (swOn) begin
          stb.memRe = 1'b1;
          memAddr   = swAddr;
          stNext    = ST_SCHK;
        end
      end
      ST_UCHK: begin
        stNext = ST_IDLE;
        if (chkSbe) begin
          stb.keepUfix = 1'b1;
          stb.bumpUser = 1'b1;
          stNext       = ST_UFIX;
        end
        if (chkDbe) begin
          stb.bumpDbe = 1'b1;
          stb.grabUe  = 1'b1;
        end
      end
      ST_UFIX: begin
        stb.memWe = 1'b1;
        stb.wrSrc = SRC_UFIX;
        memAddr   = uAddrQ;
        stNext    = ST_IDLE;
      end
      ST_SCHK: begin
        stNext = ST_IDLE;
        if (chkSbe) begin
          stb.keepSfix  = 1'b1;
          stb.bumpSweep = 1'b1;
        end
        if (chkDbe) begin
          stb.bumpDbe = 1'b1;
          stb.grabUe  = 1'b1;
        end
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st     <= ST_IDLE;
      uAddrQ <= '0;
      swAddr <= '0;
      swOn   <= 1'b0;
      swPend <= 1'b0;
      tmr    <= '0;
    end else begin
      st <= stNext;
      if (accept && !reqWrite) uAddrQ <= reqAddr;
      if (cfgInterval == '0) begin
        tmr    <= '0;
        swOn   <= 1'b0;
        swPend <= 1'b0;
        swAddr <= '0;
      end else begin
        tmr <= expire ? '0 : tmr + 1'b1;
        if (st == ST_SCHK && chkSbe) swPend <= 1'b1;
        else if (pendDone || pendCancel) swPend <= 1'b0;
        if (sweepStep) begin
          if (swAddr == LAST_ADDR) begin
            swOn   <= 1'b0;
            swAddr <= '0;
          end else swAddr <= swAddr + 1'b1;
        end else if (expire && !swOn) swOn <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ecc_scrub_ctrl.sv
module ecc_scrub_ctrl
  import ecc_scrub_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 8,
  parameter int IV_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              rspSbe,
  output logic              rspDbe,
  input  logic [IV_W-1:0]   cfgInterval,
  output logic              uePulse,
  output logic [ADDR_W-1:0] ueAddr,
  output logic [CNT_W-1:0]  cntUserSbe,
  output logic [CNT_W-1:0]  cntSweepSbe,
  output logic [CNT_W-1:0]  cntDbe
);
  strobe_t           stb;
  logic [ADDR_W-1:0] memAddr;
  logic              chkSbe, chkDbe;

  ecc_scrub_ctl #(.ADDR_W(ADDR_W), .IV_W(IV_W)) uCtl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .cfgInterval(cfgInterval), .chkSbe(chkSbe),
    .chkDbe(chkDbe), .reqReady(reqReady), .rspValid(rspValid),
    .stb(stb), .memAddr(memAddr)
  );

  ecc_scrub_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .memAddr(memAddr), .wrData(reqWdata),
    .rdData(rspData), .chkSbe(chkSbe), .chkDbe(chkDbe), .uePulse(uePulse),
    .ueAddr(ueAddr), .cntUserSbe(cntUserSbe), .cntSweepSbe(cntSweepSbe),
    .cntDbe(cntDbe)
  );

  assign rspSbe = rspValid & chkSbe;
  assign rspDbe = rspValid & chkDbe;
endmodule

// File: rtl/ecc_scrub_chk.sv
module ecc_scrub_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic             reqWrite,
  input logic             rspValid,
  input logic             rspSbe,
  input logic             rspDbe,
  input logic             uePulse,
  input logic [CNT_W-1:0] cntUserSbe,
  input logic [CNT_W-1:0] cntSweepSbe,
  input logic [CNT_W-1:0] cntDbe
);
  assert_read_resp_R1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !reqWrite) |=> rspValid);

  assert_resp_stall_R1: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !reqReady);

  assert_fix_stall_R3: assert property (@(posedge clk) disable iff (!rstN)
    rspSbe |=> (!reqReady ##1 reqReady));

  assert_flags_excl_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(rspSbe && rspDbe));

  assert_ue_count_R4: assert property (@(posedge clk) disable iff (!rstN)
    uePulse |-> ((cntDbe != $past(cntDbe)) || (cntDbe == '1)));

  assert_write_ready_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqWrite) |=> (reqReady && !rspValid));

  assert_cnt_mono_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cntUserSbe >= $past(cntUserSbe)) && (cntSweepSbe >= $past(cntSweepSbe))
    && (cntDbe >= $past(cntDbe)));
endmodule

bind ecc_scrub_ctrl ecc_scrub_chk #(.CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqWrite(reqWrite), .rspValid(rspValid), .rspSbe(rspSbe), .rspDbe(rspDbe),
  .uePulse(uePulse), .cntUserSbe(cntUserSbe), .cntSweepSbe(cntSweepSbe),
  .cntDbe(cntDbe)
);

// File: tb/test_ecc_scrub_ctrl.sv
module test_ecc_scrub_ctrl;
  localparam int DATA_W = 64;
  localparam int ADDR_W = 4;
  localparam int CNT_W  = 8;
  localparam int IV_W   = 16;
  localparam int CW     = 72;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic              reqWrite = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic              rspValid;
  logic [DATA_W-1:0] rspData;
  logic              rspSbe, rspDbe;
  logic [IV_W-1:0]   cfgInterval = '0;
  logic              uePulse;
  logic [ADDR_W-1:0] ueAddr;
  logic [CNT_W-1:0]  cntUserSbe, cntSweepSbe, cntDbe;

  int vectors = 0;
  int fails = 0;
  bit finished = 0;
  int expUser = 0, expSweep = 0, expDbe = 0;

  // captured by doRead
  logic [DATA_W-1:0] gotData;
  logic gotValid, gotSbe, gotDbe, gotRdy1, gotRdy2, gotUe;
  logic [ADDR_W-1:0] gotUeAddr;

  always #10 clk = ~clk;

  ecc_scrub_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .IV_W(IV_W))
    i_ecc_scrub_ctrl (
      .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
      .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
      .rspValid(rspValid), .rspData(rspData), .rspSbe(rspSbe), .rspDbe(rspDbe),
      .cfgInterval(cfgInterval), .uePulse(uePulse), .ueAddr(ueAddr),
      .cntUserSbe(cntUserSbe), .cntSweepSbe(cntSweepSbe), .cntDbe(cntDbe));

  function automatic logic [63:0] pat(int a, int salt);
    return {32'hC3A5_0000 ^ 32'(salt * 32'h1357), 32'h0F0F_0000 | 32'(a)} ^ (64'h1 << (a * 3 + salt));
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic flipBit(input int a, input int b);
    @(negedge clk);
    i_ecc_scrub_ctrl.uDp.mem[a][b] = ~i_ecc_scrub_ctrl.uDp.mem[a][b];
  endtask

  task automatic doWrite(input int a, input logic [63:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = ADDR_W'(a); reqWdata = d;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
  endtask

  task automatic doRead(input int a);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = ADDR_W'(a);
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    gotValid = rspValid; gotData = rspData; gotSbe = rspSbe; gotDbe = rspDbe;
    @(negedge clk);
    gotRdy1 = reqReady; gotUe = uePulse; gotUeAddr = ueAddr;
    @(negedge clk);
    gotRdy2 = reqReady;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset;
    chk("R10 reset cntUserSbe", 64'(cntUserSbe), 0);
    chk("R10 reset cntSweepSbe", 64'(cntSweepSbe), 0);
    chk("R10 reset cntDbe", 64'(cntDbe), 0);
    chk("R1 reset rspValid", 64'(rspValid), 0);
    chk("R4 reset uePulse", 64'(uePulse), 0);
    chk("R8 reset reqReady", 64'(reqReady), 1);
  endtask

  task automatic testCleanRead;
    for (int a = 0; a < 16; a++) doWrite(a, pat(a, 0));
    for (int a = 0; a < 16; a += 5) begin
      doRead(a);
      chk("R1 clean rspValid", 64'(gotValid), 1);
      chk("R1 clean data", gotData, pat(a, 0));
      chk("R1 clean flags", {62'd0, gotSbe, gotDbe}, 0);
      chk("R1 clean ready after response", 64'(gotRdy1), 1);
    end
  endtask

  task automatic testSingle;
    int bits[3] = '{5, 0, CW - 1};
    for (int k = 0; k < 3; k++) begin
      flipBit(3 + k, bits[k]);
      doRead(3 + k);
      expUser++;
      chk("R2 sbe data", gotData, pat(3 + k, 0));
      chk("R2 sbe flag", {62'd0, gotSbe, gotDbe}, 2);
      chk("R2 user counter", 64'(cntUserSbe), 64'(expUser));
      chk("R3 stall during write-back", 64'(gotRdy1), 0);
      chk("R3 ready after write-back", 64'(gotRdy2), 1);
      doRead(3 + k);
      chk("R3 repaired in array", {62'd0, gotSbe, gotDbe}, 0);
      chk("R3 repaired data", gotData, pat(3 + k, 0));
    end
  endtask

  task automatic testDouble;
    flipBit(7, 10);
    flipBit(7, 40);
    for (int k = 0; k < 2; k++) begin
      doRead(7);
      expDbe++;
      chk("R4 dbe flags", {62'd0, gotSbe, gotDbe}, 1);
      chk("R4 uePulse", 64'(gotUe), 1);
      chk("R4 ueAddr", 64'(gotUeAddr), 7);
      chk("R4 dbe counter", 64'(cntDbe), 64'(expDbe));
      chk("R4 no user sbe count", 64'(cntUserSbe), 64'(expUser));
    end
    chk("R4 uePulse one cycle", 64'(uePulse), 0);
  endtask

  task automatic testWriteClears;
    doWrite(7, pat(7, 1));
    chk("R5 ready after write", 64'(reqReady), 1);
    chk("R5 no response to write", 64'(rspValid), 0);
    doRead(7);
    chk("R5 double cleared by write", {62'd0, gotSbe, gotDbe}, 0);
    chk("R5 new data", gotData, pat(7, 1));
    flipBit(8, 33);
    doWrite(8, pat(8, 1));
    doRead(8);
    chk("R5 single cleared by write", {62'd0, gotSbe, gotDbe}, 0);
    chk("R5 counters unchanged", {32'(cntUserSbe), 32'(cntDbe)}, {32'(expUser), 32'(expDbe)});
  endtask

  task automatic testDisabled;
    flipBit(9, 2);
    waitCycles(100);
    chk("R7 sweep counter idle", 64'(cntSweepSbe), 0);
    doRead(9);
    expUser++;
    chk("R7 fault left in array", {62'd0, gotSbe, gotDbe}, 2);
    chk("R7 data", gotData, pat(9, 0));
  endtask

  task automatic testSweep;
    int n = 0;
    flipBit(1, 17);
    flipBit(5, 63);
    flipBit(15, 70);
    flipBit(12, 3);
    flipBit(12, 50);
    @(negedge clk);
    cfgInterval = 16'd50;
    while (cntSweepSbe != 3 && n < 400) begin
      @(negedge clk);
      n++;
    end
    waitCycles(4);
    cfgInterval = '0;
    expSweep = 3;
    expDbe++;
    chk("R6 sweep counter", 64'(cntSweepSbe), 3);
    chk("R6 sweep dbe counter", 64'(cntDbe), 64'(expDbe));
    chk("R6 sweep ueAddr", 64'(ueAddr), 12);
    doRead(1);
    chk("R6 addr 1 repaired", {62'd0, gotSbe, gotDbe}, 0);
    doRead(5);
    chk("R6 addr 5 repaired", {62'd0, gotSbe, gotDbe}, 0);
    doRead(15);
    chk("R6 last addr repaired", {62'd0, gotSbe, gotDbe}, 0);
    chk("R6 last addr data", gotData, pat(15, 0));
    chk("R6 no user count", 64'(cntUserSbe), 64'(expUser));
    doWrite(12, pat(12, 0));
  endtask

  task automatic testCancel;
    int n = 0;
    flipBit(0, 22);
    @(negedge clk);
    cfgInterval = 16'd20;
    while (cntSweepSbe == CNT_W'(expSweep) && n < 200) begin
      @(negedge clk);
      n++;
    end
    // write-back is pending in this cycle
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = '0; reqWdata = pat(0, 5);
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
    waitCycles(60);
    cfgInterval = '0;
    expSweep++;
    chk("R9 sweep counter", 64'(cntSweepSbe), 64'(expSweep));
    doRead(0);
    chk("R9 user write survives", gotData, pat(0, 5));
    chk("R9 no fault", {62'd0, gotSbe, gotDbe}, 0);
  endtask

  task automatic testPriority;
    bit allReady = 1;
    @(negedge clk);
    cfgInterval = 16'd3;
    waitCycles(10);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = '0; reqWdata = pat(0, 2);
    while (!reqReady) @(negedge clk);
    for (int k = 0; k < 16; k++) begin
      reqAddr = ADDR_W'(k); reqWdata = pat(k, 2);
      if (!reqReady) allReady = 0;
      @(negedge clk);
    end
    reqValid = 1'b0; reqWrite = 1'b0;
    chk("R8 back-to-back writes accepted", 64'(allReady), 1);
    waitCycles(40);
    cfgInterval = '0;
    doRead(0);
    chk("R8 first write data", gotData, pat(0, 2));
    doRead(15);
    chk("R8 last write data", gotData, pat(15, 2));
    chk("R8 sweep found nothing", 64'(cntSweepSbe), 64'(expSweep));
  endtask

  task automatic testSaturate;
    bit allSbe = 1;
    for (int k = 0; k < 260; k++) begin
      flipBit(2, k % CW);
      doRead(2);
      if (!gotSbe || gotData !== pat(2, 2)) allSbe = 0;
      if (expUser < 255) expUser++;
    end
    chk("R2 repeated single repairs", 64'(allSbe), 1);
    chk("R10 user counter saturates", 64'(cntUserSbe), 255);
    chk("R10 other counters", {32'(cntSweepSbe), 32'(cntDbe)}, {32'(expSweep), 32'(expDbe)});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    waitCycles(3);
    rstN = 1'b1;
    waitCycles(2);
    testReset;
    testCleanRead;
    testSingle;
    testDouble;
    testWriteClears;
    testDisabled;
    testSweep;
    testCancel;
    testPriority;
    testSaturate;
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule